// File: doc/BRIEF.md
# Slot-Indexed Vector Sum-Reduction Unit

This unit combines integer vector chunks sent by a fixed group of workers. Each incoming packet names one of several aggregation slots, the worker that sent it, a chunk of element values and one extra signed scalar. The chunk is added, element by element, into the slot's accumulators. The scalar is folded into a running per-slot maximum. Because every slot is independent, the number of slots bounds how many reductions can be in flight at the same time.

When a packet brings a slot's contributor set to the full worker group, the unit copies the final sums and the maximum into an output buffer. In that same cycle it clears the slot, so the slot can start a new round. The buffer is then streamed out as one header beat, which carries the maximum and the slot id, followed by one beat per element. While the stream runs, the input is held off. A second packet from a worker that has already contributed to the current round is discarded and reported on a one-cycle flag.

Top module: `slot_allreduce`

## Requirements
- R1: After reset, `out_valid` and `dup_err` are 0 and `in_ready` is 1.
- R2: Each released element equals the sum of that element over the round's contributions, computed in 32-bit two's complement with wraparound on overflow.
- R3: A slot produces no output until contributions from all 4 distinct worker ids (0..3) have been accepted for it. The packet that completes the set starts the release.
- R4: The header beat's `out_data` is the signed maximum of the `in_max` values accepted in that round.
- R5: A release begins on the cycle after the completing packet is accepted. It lasts 1+K consecutive cycles. Beat 0 has `out_hdr`=1 and carries the slot id. Beats 1..K carry elements 0..K-1 in order, where element i of the input is taken from `in_elems[i*32 +: 32]`. `out_last`=1 only on beat K.
- R6: A released slot starts its next round empty: its sums, its maximum and its contributor set are all cleared.
- R7: A packet whose worker has already contributed to the slot's current round changes no state. `dup_err` is 1 on the cycle after that packet is accepted and 0 after any other accepted packet.
- R8: Slots accumulate independently of each other, so rounds on different slots may be interleaved packet by packet.
- R9: `in_ready` is 0 during every output beat. It returns to 1 on the cycle after the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input packet present |
| in_ready | output | 1 | Unit can take a packet |
| in_slot | input | 3 | Slot index |
| in_worker | input | 2 | Sending worker id |
| in_elems | input | 256 | K=8 elements of 32 bits, element i at bits i*32 +: 32 |
| in_max | input | 32 | Signed scalar for the running maximum |
| out_valid | output | 1 | Output beat present |
| out_hdr | output | 1 | Header beat marker |
| out_last | output | 1 | Final element beat |
| out_slot | output | 3 | Slot id of the release |
| out_data | output | 32 | Maximum on the header beat, otherwise the element sum |
| dup_err | output | 1 | Duplicate contribution dropped |

## Verification
Directed rounds send one slot's four workers in order. Other rounds send them in a shuffled order mixed with repeats. This separates a release that counts packets from one that tracks distinct workers. Rounds interleaved across two slots show whether any state leaks between slots. Elements of 0x7FFFFFFF and rounds whose scalars are all negative expose sums that saturate instead of wrapping, and maximum comparisons that treat the scalar as unsigned. A long seeded random mix of slots, workers, values and duplicates then runs against a reference model in the bench. It also re-checks that each slot restarts empty after every release.

// File: rtl/slot_allreduce.sv
module slot_allreduce #(
  parameter int N_WORKERS = 4,
  parameter int SLOTS     = 8,
  parameter int K         = 8,
  parameter int W         = 32,
  parameter int SLOT_W    = $clog2(SLOTS),
  parameter int WID_W     = $clog2(N_WORKERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SLOT_W-1:0]    in_slot,
  input  logic [WID_W-1:0]     in_worker,
  input  logic [K*W-1:0]       in_elems,
  input  logic signed [W-1:0]  in_max,
  output logic                 out_valid,
  output logic                 out_hdr,
  output logic                 out_last,
  output logic [SLOT_W-1:0]    out_slot,
  output logic [W-1:0]         out_data,
  output logic                 dup_err
);
  localparam int BEAT_W = $clog2(K + 1);
  localparam int IDX_W  = (K > 1) ? $clog2(K) : 1;

  logic signed [W-1:0] acc [SLOTS][K];
  logic signed [W-1:0] mx [SLOTS];
  logic [N_WORKERS-1:0] seen [SLOTS];

  logic signed [W-1:0] obuf [K];
  logic signed [W-1:0] omax;
  logic [SLOT_W-1:0]   oslot;
  logic                busy;
  logic [BEAT_W-1:0]   beat;

  logic [N_WORKERS-1:0] wbit;
  logic signed [W-1:0]  sum [K];
  logic signed [W-1:0]  new_max;
  logic                 accept, dup, done;
  logic [BEAT_W-1:0]    eidx;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign dup      = seen[in_slot][in_worker];
  assign done     = (seen[in_slot] | wbit) == {N_WORKERS{1'b1}};
  assign new_max  = (seen[in_slot] == '0 || in_max > mx[in_slot]) ? in_max : mx[in_slot];

  always_comb begin
    wbit = '0;
    wbit[in_worker] = 1'b1;
    for (int i = 0; i < K; i++)
      sum[i] = acc[in_slot][i] + $signed(in_elems[i*W +: W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) begin
        for (int i = 0; i < K; i++) acc[s][i] <= '0;
        mx[s]   <= '0;
        seen[s] <= '0;
      end
      for (int i = 0; i < K; i++) obuf[i] <= '0;
      omax    <= '0;
      oslot   <= '0;
      busy    <= 1'b0;
      beat    <= '0;
      dup_err <= 1'b0;
    end else begin
      dup_err <= accept && dup;
      if (busy) begin
        if (beat == BEAT_W'(K)) busy <= 1'b0;
        else beat <= beat + 1'b1;
      end else if (accept && !dup) begin
        if (done) begin
          for (int i = 0; i < K; i++) begin
            obuf[i]          <= sum[i];
            acc[in_slot][i]  <= '0;
          end
          omax          <= new_max;
          oslot         <= in_slot;
          busy          <= 1'b1;
          beat          <= '0;
          mx[in_slot]   <= '0;
          seen[in_slot] <= '0;
        end else begin
          for (int i = 0; i < K; i++) acc[in_slot][i] <= sum[i];
          mx[in_slot]   <= new_max;
          seen[in_slot] <= seen[in_slot] | wbit;
        end
      end
    end
  end

  assign eidx      = beat - 1'b1;
  assign out_valid = busy;
  assign out_hdr   = busy && beat == '0;
  assign out_last  = busy && beat == BEAT_W'(K);
  assign out_slot  = oslot;
  assign out_data  = (beat == '0) ? omax : obuf[eidx[IDX_W-1:0]];

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !out_valid && !dup_err && in_ready);
  assert_start_with_header_R5: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_valid) |-> out_hdr);
  assert_stream_unbroken_R5: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_last |=> out_valid && !out_hdr);
  assert_release_needs_accept_R3: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_valid) |-> $past(in_valid && in_ready));
  assert_dup_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n) dup_err |-> $past(in_valid && in_ready));
  assert_no_ready_streaming_R9: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !in_ready);
  assert_ready_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n) out_last |=> in_ready && !out_valid);
endmodule

// File: tb/slot_allreduce_tb_top.sv
module slot_allreduce_tb_top;
  localparam int NW = 4, S = 8, K = 8, W = 32;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [2:0] in_slot = 0;
  logic [1:0] in_worker = 0;
  logic [K*W-1:0] in_elems = '0;
  logic signed [W-1:0] in_max = 0;
  logic out_valid, out_hdr, out_last, dup_err;
  logic [2:0] out_slot;
  logic [W-1:0] out_data;

  int total = 0, fails = 0;
  int macc [S][K];
  int mmax [S];
  logic [NW-1:0] mseen [S];

  always #4 clk = ~clk;

  slot_allreduce dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_slot(in_slot), .in_worker(in_worker), .in_elems(in_elems), .in_max(in_max),
    .out_valid(out_valid), .out_hdr(out_hdr), .out_last(out_last),
    .out_slot(out_slot), .out_data(out_data), .dup_err(dup_err));

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int wmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic send(input int slot, input int wk, input logic [K*W-1:0] d, input int mx);
    bit exp_dup, complete;
    int esum [K];
    int emax;
    exp_dup = mseen[slot][wk];
    complete = 0;
    emax = 0;
    if (!exp_dup) begin
      for (int i = 0; i < K; i++) macc[slot][i] = macc[slot][i] + int'(d[i*W +: W]);
      mmax[slot] = (mseen[slot] == '0) ? mx : wmax(mmax[slot], mx);
      mseen[slot][wk] = 1'b1;
      if (mseen[slot] == 4'hF) begin
        complete = 1;
        for (int i = 0; i < K; i++) begin esum[i] = macc[slot][i]; macc[slot][i] = 0; end
        emax = mmax[slot];
        mmax[slot] = 0;
        mseen[slot] = '0;
      end
    end
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_slot = 3'(slot); in_worker = 2'(wk); in_elems = d; in_max = mx;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk(dup_err == exp_dup, "R7", "dup_err", dup_err, exp_dup);
    if (complete) begin
      chk(out_valid && out_hdr, "R5", "header beat", {out_valid, out_hdr}, 2'b11);
      chk(out_slot == 3'(slot), "R5", "out_slot", out_slot, slot);
      chk(out_data == emax, "R4", "max", out_data, emax);
      chk(!in_ready, "R9", "in_ready in header", in_ready, 0);
      for (int e = 0; e < K; e++) begin
        @(negedge clk);
        chk(out_data == esum[e], "R2", $sformatf("sum elem %0d", e), out_data, esum[e]);
        chk(out_valid && !out_hdr && out_last == (e == K-1), "R5", "beat flags",
            {out_valid, out_hdr, out_last}, {2'b10, e == K-1});
        chk(!in_ready, "R9", "in_ready in stream", in_ready, 0);
      end
      @(negedge clk);
      chk(!out_valid && in_ready, "R9", "idle after last", {out_valid, in_ready}, 2'b01);
    end else begin
      chk(!out_valid, "R3", "no early release", out_valid, 0);
    end
  endtask

  function automatic logic [K*W-1:0] rnd_vec();
    logic [K*W-1:0] v;
    for (int i = 0; i < K; i++) v[i*W +: W] = $urandom;
    return v;
  endfunction

  initial begin
    #(8*150000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [K*W-1:0] v;
    void'($urandom(32'd4242));
    for (int s = 0; s < S; s++) begin
      mseen[s] = '0; mmax[s] = 0;
      for (int i = 0; i < K; i++) macc[s][i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !dup_err && in_ready, "R1", "reset state", {out_valid, dup_err, in_ready}, 3'b001);

    // R2/R3/R4 in-order round on slot 1
    for (int w = 0; w < NW; w++) begin
      for (int i = 0; i < K; i++) v[i*W +: W] = 32'(i * 10 + w);
      send(1, w, v, w * 5 - 3);
    end
    // R2 wraparound, R4 all-negative maxima
    for (int i = 0; i < K; i++) v[i*W +: W] = 32'h7FFFFFFF;
    send(6, 2, v, -50); send(6, 0, v, -7); send(6, 3, v, -9); send(6, 1, v, -1000);
    // R7 duplicates, R3 shuffled order
    send(3, 2, rnd_vec(), 11);
    send(3, 2, rnd_vec(), 999);
    send(3, 0, rnd_vec(), -4);
    send(3, 0, rnd_vec(), 5000);
    send(3, 3, rnd_vec(), 2);
    send(3, 1, rnd_vec(), 1);
    // R6 slot reuse: fresh round on slot 3
    for (int w = 3; w >= 0; w--) send(3, w, rnd_vec(), -w);
    // R8 interleaved slots
    for (int w = 0; w < NW; w++) begin
      send(2, w, rnd_vec(), $urandom);
      send(5, NW - 1 - w, rnd_vec(), $urandom);
    end
    // random mix
    for (int n = 0; n < 1500; n++)
      send($urandom % S, $urandom % NW, rnd_vec(), $urandom);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule